// File: doc/BRIEF.md
# I2C SCL Clock Generator with Prescaler

This block times the serial clock of an I2C master. A prescaler divides the functional clock into a slower module-clock tick. Two phase counters, clocked by that tick, set how long SCL stays driven low and how long it stays released. Each phase register has a fixed hardware offset added to it: seven ticks for the low phase and five for the high phase. The transfer engine that sits next to the block receives two single-cycle strobes. One marks the first cycle of every low phase, when new data may be put on SDA. The other marks the middle of every high phase, when SDA should be sampled.

The generator watches the real level of SCL. When it has released the line but the line still reads low, a slave is holding the clock. The high-phase count and the prescaler then freeze until the line rises, which supports clock stretching. While the block is disabled, SCL stays released, no strobes fire and all counters stay at zero. The divider and phase settings are captured only while the block is disabled. Writes made while it runs are ignored until the next enable.

As an example, a 12 MHz module clock with 30 ticks per phase gives a 200 kHz SCL. For that rate the low register is written with 23 and the high register with 25.

Top module: `i2c_scl_clkgen`

## Requirements
- R1: The module tick occurs once every (div_cfg + 1) clock cycles while a phase is counting. Every phase length in clock cycles is therefore its tick count multiplied by (div_cfg + 1).
- R2: Each SCL low phase (scl_pull = 1) lasts exactly (low_cfg + 7) module ticks.
- R3: Each SCL high phase (scl_pull = 0 while enabled), when not stretched, lasts exactly (high_cfg + 5) module ticks. The next low phase then begins.
- R4: drive_stb is a one-cycle pulse in the first clock cycle of every low phase, the cycle in which scl_pull goes from 0 to 1.
- R5: sample_stb is a one-cycle pulse issued floor((high_cfg + 5) / 2) module ticks after the high phase begins. Without stretching, that is the cycle high_start + floor((high_cfg+5)/2) × (div_cfg+1).
- R6: During a high phase, each clock edge at which scl_sense reads 0 halts both the prescaler and the high-phase count. All later events slip by the number of such edges, and scl_pull stays 0 for the whole stretch.
- R7: While run_en is 0, scl_pull is 0 and neither strobe fires. When run_en is sampled at 1, the first low phase starts in the next cycle, with the prescaler and the phase counter both starting from zero.
- R8: Changes to div_cfg, low_cfg and high_cfg while run_en is 1 have no effect on timing. The values are captured only while run_en is 0.
- R9: After reset, scl_pull, drive_stb and sample_stb are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Generator enable; configuration is captured while low |
| div_cfg | input | DIV_W | Prescaler value; module tick = clk / (div_cfg+1) |
| low_cfg | input | PH_W | Low-phase setting; low lasts low_cfg+7 ticks |
| high_cfg | input | PH_W | High-phase setting; high lasts high_cfg+5 ticks |
| scl_sense | input | 1 | Observed SCL level (1 = high), synchronous to clk |
| scl_pull | output | 1 | 1 = drive SCL low, 0 = release SCL |
| drive_stb | output | 1 | One-cycle strobe at the start of each low phase |
| sample_stb | output | 1 | One-cycle strobe at the middle of each high phase |

## Verification
A wrong prescaler or phase count would not stay hidden inside the block. It would move the very next scl_pull edge or strobe by at least one clock. So within one SCL period, the scoreboard sees the event arrive at the wrong clock cycle compared with the cycle computed from the settings. A stretch that fails to freeze the counters, or that freezes them too long, shifts the mid-high strobe in the same phase. Configuration that leaks in during a run changes the length of the following phase. A generator that keeps counting when disabled shows up as a strobe or as a low SCL inside the idle window the bench watches.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;

    // fixed hardware additions to the programmed phase settings
    localparam int LOW_EXTRA  = 7;
    localparam int HIGH_EXTRA = 5;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic drive;
        logic sample;
    } strobe_t;

endpackage

// File: rtl/i2c_sclgen_cfg.sv
module i2c_sclgen_cfg
    import i2c_sclgen_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PH_W  = 8,
    localparam int LEN_W = PH_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [DIV_W-1:0] div_in,
    input  logic [PH_W-1:0]  low_in,
    input  logic [PH_W-1:0]  high_in,
    output logic [DIV_W-1:0] div_q,
    output logic [LEN_W-1:0] low_len_q,
    output logic [LEN_W-1:0] high_len_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q      <= '0;
            low_len_q  <= LEN_W'(LOW_EXTRA);
            high_len_q <= LEN_W'(HIGH_EXTRA);
        end else if (!run_en) begin
            div_q      <= div_in;
            low_len_q  <= {1'b0, low_in} + LEN_W'(LOW_EXTRA);
            high_len_q <= {1'b0, high_in} + LEN_W'(HIGH_EXTRA);
        end
    end

    // settings frozen while running (R8)
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        run_en |=> ($stable(div_q) && $stable(low_len_q) && $stable(high_len_q)));

endmodule

// File: rtl/i2c_sclgen_presc.sv
module i2c_sclgen_presc #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cnt_en,
    input  logic [DIV_W-1:0] div_val,
    output logic             mtick
);

    logic [DIV_W-1:0] pcnt_q;

    assign mtick = cnt_en && !clr && (pcnt_q == div_val);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt_q <= '0;
        end else if (cnt_en) begin
            pcnt_q <= mtick ? '0 : pcnt_q + DIV_W'(1);
        end
    end

    // two ticks are never adjacent unless dividing by one (R1)
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        (mtick && div_val != '0 && !clr) |=> !mtick);

    // a frozen prescaler keeps its count (R6)
    p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !cnt_en) |=> $stable(pcnt_q));

endmodule

// File: rtl/i2c_sclgen_phase.sv
module i2c_sclgen_phase
    import i2c_sclgen_pkg::*;
#(
    parameter int PH_W = 8,
    localparam int LEN_W = PH_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             mtick,
    input  logic             scl_sense,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    output logic             presc_clr,
    output logic             presc_run,
    output logic             scl_pull,
    output strobe_t          stb
);

    phase_e           state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    strobe_t          stb_q, stb_d;
    logic             stall;
    logic [LEN_W-1:0] mid_point;

    assign stall     = (state_q == PH_HIGH) && !scl_sense;
    assign presc_clr = (state_q == PH_OFF);
    assign presc_run = (state_q != PH_OFF) && !stall;
    assign mid_point = (high_len >> 1) - LEN_W'(1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!run_en) begin
            state_d = PH_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PH_OFF: begin
                    state_d = PH_LOW;
                    cnt_d   = '0;
                end
                PH_LOW: if (mtick) begin
                    if (cnt_q == low_len - LEN_W'(1)) begin
                        state_d = PH_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + LEN_W'(1);
                    end
                end
                PH_HIGH: if (mtick) begin
                    if (cnt_q == high_len - LEN_W'(1)) begin
                        state_d = PH_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + LEN_W'(1);
                    end
                end
                default: begin
                    state_d = PH_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        stb_d.drive  = (state_d == PH_LOW) && (state_q != PH_LOW);
        stb_d.sample = run_en && (state_q == PH_HIGH) && mtick && (cnt_q == mid_point);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_OFF;
            cnt_q   <= '0;
            stb_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            stb_q   <= stb_d;
        end
    end

    assign scl_pull = (state_q == PH_LOW);
    assign stb      = stb_q;

    // idle while disabled (R7)
    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!scl_pull && !stb_q.drive && !stb_q.sample));

    // drive strobe only on the first low cycle (R4)
    p_drive_edge_r4: assert property (@(posedge clk) disable iff (rst)
        stb_q.drive |-> (scl_pull && !$past(scl_pull)));

    // a held line keeps the generator released (R6)
    p_stretch_release_r6: assert property (@(posedge clk) disable iff (rst)
        (run_en && stall) |=> !scl_pull);

    // sampling strobe belongs to the high phase (R5)
    p_sample_in_high_r5: assert property (@(posedge clk) disable iff (rst)
        stb_q.sample |-> (state_q == PH_HIGH));

    // low count never passes its length (R2)
    p_low_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_LOW) |-> (cnt_q < low_len));

endmodule

// File: rtl/i2c_scl_clkgen.sv
module i2c_scl_clkgen
    import i2c_sclgen_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PH_W  = 8,
    localparam int LEN_W = PH_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic [PH_W-1:0]  low_cfg,
    input  logic [PH_W-1:0]  high_cfg,
    input  logic             scl_sense,
    output logic             scl_pull,
    output logic             drive_stb,
    output logic             sample_stb
);

    logic [DIV_W-1:0] div_q;
    logic [LEN_W-1:0] low_len, high_len;
    logic             mtick, presc_clr, presc_run;
    strobe_t          stb;

    i2c_sclgen_cfg #(.DIV_W(DIV_W), .PH_W(PH_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .div_in     (div_cfg),
        .low_in     (low_cfg),
        .high_in    (high_cfg),
        .div_q      (div_q),
        .low_len_q  (low_len),
        .high_len_q (high_len)
    );

    i2c_sclgen_presc #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .clr     (presc_clr),
        .cnt_en  (presc_run),
        .div_val (div_q),
        .mtick   (mtick)
    );

    i2c_sclgen_phase #(.PH_W(PH_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .mtick     (mtick),
        .scl_sense (scl_sense),
        .low_len   (low_len),
        .high_len  (high_len),
        .presc_clr (presc_clr),
        .presc_run (presc_run),
        .scl_pull  (scl_pull),
        .stb       (stb)
    );

    assign drive_stb  = stb.drive;
    assign sample_stb = stb.sample;

    // strobes are single-cycle (R4, R5)
    p_drive_single_r4: assert property (@(posedge clk) disable iff (rst)
        drive_stb |=> !drive_stb);
    p_sample_single_r5: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);

endmodule

// File: tb/i2c_scl_clkgen_test.sv
module i2c_scl_clkgen_test;

    localparam int EV_DRIVE  = 0;
    localparam int EV_RISE   = 1;
    localparam int EV_SAMPLE = 2;

    typedef struct {
        int    kind;
        int    cyc;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic [7:0] div_cfg = '0;
    logic [7:0] low_cfg = '0;
    logic [7:0] high_cfg = '0;
    logic       slave_hold = 1'b0;
    logic       scl_sense;
    logic       scl_pull, drive_stb, sample_stb;

    int   cyc = 0;
    int   total = 0;
    int   fails = 0;
    logic prev_pull = 1'b0;
    exp_t sb[$];

    assign scl_sense = !(scl_pull || slave_hold);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_scl_clkgen uut (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .div_cfg    (div_cfg),
        .low_cfg    (low_cfg),
        .high_cfg   (high_cfg),
        .scl_sense  (scl_sense),
        .scl_pull   (scl_pull),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb)
    );

    function automatic string kname(int k);
        return (k == EV_DRIVE) ? "drive" : (k == EV_RISE) ? "rise" : "sample";
    endfunction

    task automatic push(int kind, int at, string tag);
        exp_t e;
        e.kind = kind; e.cyc = at; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic got(int kind);
        exp_t e;
        total++;
        if (sb.size() == 0) begin
            fails++;
            $display("FAIL unexpected: %s at cycle %0d, expected nothing", kname(kind), cyc);
        end else begin
            e = sb.pop_front();
            if (e.kind != kind || e.cyc != cyc) begin
                fails++;
                $display("FAIL %s: got %s at cycle %0d, expected %s at cycle %0d",
                         e.tag, kname(kind), cyc, kname(e.kind), e.cyc);
            end
        end
    endtask

    // monitor: compare produced events with the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (run_en && prev_pull && !scl_pull) got(EV_RISE);
            if (sample_stb) got(EV_SAMPLE);
            if (drive_stb) begin
                got(EV_DRIVE);
                total++;
                if (!(scl_pull && !prev_pull)) begin
                    fails++;
                    $display("FAIL R4: drive strobe with pull=%0b prev=%0b, expected 1/0",
                             scl_pull, prev_pull);
                end
            end
        end
        prev_pull = scl_pull;
    end

    task automatic check_empty(string tag);
        total++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d events missing, expected 0", tag, sb.size());
        end
    endtask

    // driver: program, enable, predict n periods, optionally stretch or disturb settings
    task automatic run_cfg(int p, int lv, int hv, int n, int d, bit chg, string base);
        int s, m, lo, hi, per, t0, stop_at;
        string tr, th, ts;
        @(negedge clk);
        div_cfg = 8'(p); low_cfg = 8'(lv); high_cfg = 8'(hv);
        repeat (2) @(negedge clk);
        run_en = 1'b1;
        s  = cyc + 1;
        m  = p + 1;
        lo = (lv + 7) * m;
        hi = (hv + 5) * m;
        per = lo + hi;
        t0 = s + lo;
        tr = chg ? "R8" : (p > 0 ? "R1/R2" : "R2");
        th = chg ? "R8" : (d > 0 ? "R6" : "R3");
        ts = (d > 0) ? "R6" : "R5";
        for (int k = 0; k < n; k++) begin
            push(EV_DRIVE, s + k * per + ((k > 0) ? d : 0), (k == 0) ? "R7" : th);
            push(EV_RISE, s + k * per + lo + ((k > 0) ? d : 0), tr);
            push(EV_SAMPLE, s + k * per + lo + d + ((hv + 5) / 2) * m, ts);
        end
        stop_at = s + n * per + d - 1;
        if (d > 0) begin
            while (cyc < t0) @(negedge clk);
            slave_hold = 1'b1;
            repeat (d) @(negedge clk);
            slave_hold = 1'b0;
        end
        if (chg) begin
            repeat (5) @(negedge clk);
            div_cfg = 8'(p + 3); low_cfg = 8'(lv + 9); high_cfg = 8'(hv + 4);
        end
        while (cyc < stop_at) @(negedge clk);
        run_en = 1'b0;
        repeat (4) @(negedge clk);
        check_empty(base);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: run still active at cycle %0d, expected completion", cyc);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        // R9: reset state
        total++;
        if (scl_pull || drive_stb || sample_stb) begin
            fails++;
            $display("FAIL R9: outputs %0b%0b%0b in reset, expected 000", scl_pull, drive_stb, sample_stb);
        end
        rst = 1'b0;
        repeat (2) @(negedge clk);
        total++;
        if (scl_pull || drive_stb || sample_stb) begin
            fails++;
            $display("FAIL R9: outputs %0b%0b%0b after reset, expected 000", scl_pull, drive_stb, sample_stb);
        end

        run_cfg(0, 0, 0, 3, 0, 1'b0, "R2");   // shortest phases, no division
        run_cfg(2, 3, 4, 2, 0, 1'b0, "R1");   // odd high length
        run_cfg(3, 8, 10, 2, 0, 1'b0, "R3");  // fast-mode style settings
        run_cfg(3, 53, 55, 2, 0, 1'b0, "R1"); // standard-mode style settings
        run_cfg(1, 1, 2, 2, 6, 1'b0, "R6");   // slave stretches first high phase
        run_cfg(1, 2, 1, 2, 0, 1'b1, "R8");   // settings disturbed while running

        // R7: disable in mid low phase, then stay idle
        @(negedge clk);
        div_cfg = 8'd2; low_cfg = 8'd0; high_cfg = 8'd0;
        repeat (2) @(negedge clk);
        run_en = 1'b1;
        push(EV_DRIVE, cyc + 1, "R7");
        repeat (4) @(negedge clk);
        run_en = 1'b0;
        repeat (2) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            if (scl_pull || drive_stb || sample_stb) bad++;
            @(negedge clk);
        end
        total++;
        if (bad != 0) begin
            fails++;
            $display("FAIL R7: %0d active cycles while disabled, expected 0", bad);
        end
        check_empty("R7");

        // R7: restart after abort begins a fresh low phase
        run_cfg(0, 1, 1, 1, 0, 1'b0, "R7");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule